// File: doc/BRIEF.md
# Triggered Fractional Clock-Rate Divider

This block turns one of several parent tick streams into a slower clock-enable pulse stream. A parent selector picks the source. An optional integer pre-divider comes next, and a downstream divider with fractional bits comes last. Software writes new field values into staging registers, and those writes have no effect at first. The new values become active only when a trigger is set while the clock gate is open.

There are two triggers. The pre-trigger moves the staged selector and pre-divider into the active set. The main trigger moves the staged downstream divider. Each trigger reads back busy from the cycle after it is set. It clears when the change lands on the next boundary of the stage it affects, or on the next cycle if the active selection names no real parent.

The downstream divider uses phase accumulation. When the divisor is not a whole number, each output period is either the floor or the ceiling of the divisor, and the periods average to the exact value.

Top module: `cr_clk_rate`

## Requirements
- R1: After reset the active selector holds SEL_RST (default 3, which is undefined with 3 parents), the active pre-divider and divider fields are 0, both busy flags are 0 and tick_o is 0.
- R2: The divider field of DIV_W bits encodes divisor = (field + 2^FRAC_W) / 2^FRAC_W, with the low FRAC_W bits (default 2) fractional. A field that is a multiple of 2^FRAC_W gives equal output periods of exactly that many pre-divided ticks.
- R3: With a fractional divisor, every output period is floor or ceil of the divisor in pre-divided ticks. Any K consecutive periods sum to floor or ceil of K times the divisor.
- R4: The pre-divider emits one tick per (pre field + 1) ticks of the selected parent. The downstream divider counts these ticks.
- R5: A staged write changes neither the active fields nor the output rate until the matching trigger commits it.
- R6: A trigger set while gate_en_i is 1 makes its busy flag read 1 from the next cycle. With a valid selection, the main trigger clears in the cycle of the next tick_o pulse. In that same cycle the new divider field is active.
- R7: The pre-trigger commits the selector and the pre-divider. The main trigger commits only the divider and leaves a staged selector untouched.
- R8: A trigger set while gate_en_i is 0 is ignored: its busy flag stays 0 and the active fields stay unchanged.
- R9: While gate_en_i is 0, tick_o stays 0 from the next cycle on.
- R10: An active selector value of NUM_SRC or more holds tick_o at 0. A trigger set under such a selection commits on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_tick_i | input | NUM_SRC | One-cycle tick per parent source |
| gate_en_i | input | 1 | Clock gate open |
| sel_wr_i | input | 1 | Write staged selector |
| sel_wdata_i | input | SEL_W | Staged selector value |
| pre_wr_i | input | 1 | Write staged pre-divider field |
| pre_wdata_i | input | PRE_W | Staged pre-divider field (divisor - 1) |
| div_wr_i | input | 1 | Write staged divider field |
| div_wdata_i | input | DIV_W | Staged divider field (scaled divisor - 2^FRAC_W) |
| trig_set_i | input | 1 | Set main trigger |
| pre_trig_set_i | input | 1 | Set pre-trigger |
| trig_busy_o | output | 1 | Main trigger pending |
| pre_trig_busy_o | output | 1 | Pre-trigger pending |
| act_sel_o | output | SEL_W | Active selector |
| act_pre_o | output | PRE_W | Active pre-divider field |
| act_div_o | output | DIV_W | Active divider field |
| tick_o | output | 1 | Divided clock-enable pulse |

## Verification
A corrupted phase accumulator shows up within one or two output periods: the period lengths leave the floor/ceil pair, or the eight-period sum drifts off the exact scaled multiple. A wrong pre-divider count shows up in the first full period as a length that is not a multiple of the parent period times the pre-division. A trigger state machine that never clears leaves a busy flag stuck high past the bounded wait. One that clears early shows up in the same cycle, as a busy fall without a tick_o pulse or as an active field that does not match the staged value.

// File: rtl/cr_pkg.sv
package cr_pkg;
  typedef enum logic {
    TRG_IDLE = 1'b0,
    TRG_BUSY = 1'b1
  } trg_state_e;

  // scaled divisor from a stored field: add one above the fraction
  function automatic int unsigned scaled_div(int unsigned field, int unsigned frac_w);
    return field + (32'd1 << frac_w);
  endfunction
endpackage

// File: rtl/cr_trigger.sv
module cr_trigger
  import cr_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic gate_en_i,
  input  logic set_i,
  input  logic boundary_i,
  output logic busy_o,
  output logic commit_o
);
  trg_state_e state_q, state_d;

  always_comb begin
    state_d  = state_q;
    commit_o = 1'b0;
    unique case (state_q)
      TRG_IDLE: if (set_i && gate_en_i) state_d = TRG_BUSY;
      TRG_BUSY: if (boundary_i) begin
        commit_o = 1'b1;
        state_d  = TRG_IDLE;
      end
      default: state_d = TRG_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= TRG_IDLE;
    else         state_q <= state_d;
  end

  assign busy_o = (state_q == TRG_BUSY);

  // R8
  trig_gated_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(set_i && gate_en_i));
  // R6
  trig_clear_on_boundary_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(boundary_i));
endmodule

// File: rtl/cr_pre_div.sv
module cr_pre_div #(
  parameter int unsigned W       = 3,
  parameter bit          HAS_PRE = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic [W-1:0] div_i,
  input  logic         clr_i,
  output logic         tick_o
);
  if (HAS_PRE) begin : g_pre
    logic [W-1:0] cnt_q;
    logic         wrap;

    assign wrap   = tick_i && (cnt_q == div_i);
    assign tick_o = wrap;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     cnt_q <= '0;
      else if (clr_i)  cnt_q <= '0;
      else if (wrap)   cnt_q <= '0;
      else if (tick_i) cnt_q <= cnt_q + 1'b1;
    end

    // R4
    pre_cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q <= div_i);
  end else begin : g_bypass
    assign tick_o = tick_i;
  end
endmodule

// File: rtl/cr_frac_div.sv
module cr_frac_div #(
  parameter int unsigned W = 6,
  parameter int unsigned F = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic [W-1:0] div_i,
  output logic         wrap_o
);
  localparam int unsigned AW = W + 1;
  localparam logic [AW-1:0] ONE = AW'(1 << F);

  logic [AW-1:0] acc_q, sum, dsc;

  assign dsc    = {1'b0, div_i} + ONE;
  assign sum    = acc_q + ONE;
  assign wrap_o = tick_i && (sum >= dsc);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (wrap_o) acc_q <= sum - dsc;
    else if (tick_i) acc_q <= sum;
  end

  // R3
  acc_below_div_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_q < dsc);
endmodule

// File: rtl/cr_clk_rate.sv
module cr_clk_rate
  import cr_pkg::*;
#(
  parameter int unsigned NUM_SRC = 3,
  parameter int unsigned SEL_W   = 2,
  parameter int unsigned PRE_W   = 3,
  parameter int unsigned DIV_W   = 6,
  parameter int unsigned FRAC_W  = 2,
  parameter bit          HAS_PRE = 1'b1,
  parameter logic [SEL_W-1:0] SEL_RST = 2'd3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_tick_i,
  input  logic               gate_en_i,
  input  logic               sel_wr_i,
  input  logic [SEL_W-1:0]   sel_wdata_i,
  input  logic               pre_wr_i,
  input  logic [PRE_W-1:0]   pre_wdata_i,
  input  logic               div_wr_i,
  input  logic [DIV_W-1:0]   div_wdata_i,
  input  logic               trig_set_i,
  input  logic               pre_trig_set_i,
  output logic               trig_busy_o,
  output logic               pre_trig_busy_o,
  output logic [SEL_W-1:0]   act_sel_o,
  output logic [PRE_W-1:0]   act_pre_o,
  output logic [DIV_W-1:0]   act_div_o,
  output logic               tick_o
);
  localparam logic [SEL_W:0] SRC_LIM = (SEL_W+1)'(NUM_SRC);

  logic [SEL_W-1:0] stg_sel_q, act_sel_q;
  logic [PRE_W-1:0] stg_pre_q, act_pre_q;
  logic [DIV_W-1:0] stg_div_q, act_div_q;
  logic sel_valid, src_sel, in_tick, pre_tick, div_wrap, tick_q;
  logic pre_commit, div_commit;

  assign sel_valid = ({1'b0, act_sel_q} < SRC_LIM);

  always_comb begin
    src_sel = 1'b0;
    for (int i = 0; i < NUM_SRC; i++)
      if (act_sel_q == SEL_W'(i)) src_sel = src_tick_i[i];
  end

  assign in_tick = gate_en_i && sel_valid && src_sel;

  // staging registers, written at any time
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_sel_q <= SEL_RST;
      stg_pre_q <= '0;
      stg_div_q <= '0;
    end else begin
      if (sel_wr_i) stg_sel_q <= sel_wdata_i;
      if (pre_wr_i) stg_pre_q <= pre_wdata_i;
      if (div_wr_i) stg_div_q <= div_wdata_i;
    end
  end

  // active registers, loaded only on commit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_sel_q <= SEL_RST;
      act_pre_q <= '0;
      act_div_q <= '0;
    end else begin
      if (pre_commit) begin
        act_sel_q <= stg_sel_q;
        act_pre_q <= stg_pre_q;
      end
      if (div_commit) act_div_q <= stg_div_q;
    end
  end

  cr_trigger u_pre_trig (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .gate_en_i  (gate_en_i),
    .set_i      (pre_trig_set_i),
    .boundary_i (pre_tick || !sel_valid),
    .busy_o     (pre_trig_busy_o),
    .commit_o   (pre_commit)
  );

  cr_trigger u_div_trig (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .gate_en_i  (gate_en_i),
    .set_i      (trig_set_i),
    .boundary_i (div_wrap || !sel_valid),
    .busy_o     (trig_busy_o),
    .commit_o   (div_commit)
  );

  cr_pre_div #(.W(PRE_W), .HAS_PRE(HAS_PRE)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (in_tick),
    .div_i  (act_pre_q),
    .clr_i  (pre_commit),
    .tick_o (pre_tick)
  );

  cr_frac_div #(.W(DIV_W), .F(FRAC_W)) u_frac (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (pre_tick),
    .div_i  (act_div_q),
    .wrap_o (div_wrap)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tick_q <= 1'b0;
    else         tick_q <= div_wrap;
  end

  assign tick_o    = tick_q;
  assign act_sel_o = act_sel_q;
  assign act_pre_o = act_pre_q;
  assign act_div_o = act_div_q;

  // R9
  gated_no_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!gate_en_i) |-> !tick_o);
  // R10
  undef_sel_no_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!sel_valid) |-> !tick_o);
  // R5
  div_change_needs_trig_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(act_div_q) |-> $past(trig_busy_o));
  // R7
  sel_change_needs_pre_trig_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(act_sel_q) || !$stable(act_pre_q)) |-> $past(pre_trig_busy_o));
endmodule

// File: tb/tb_cr_clk_rate.sv
`timescale 1ns/1ps
module tb_cr_clk_rate;
  localparam int NUM_SRC = 3;
  localparam int SEL_W   = 2;
  localparam int PRE_W   = 3;
  localparam int DIV_W   = 6;
  localparam int FRAC_W  = 2;
  localparam int ONE     = 1 << FRAC_W;
  localparam int K       = 8;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [NUM_SRC-1:0] src_tick = '0;
  logic gate_en = 1'b0;
  logic sel_wr = 1'b0, pre_wr = 1'b0, div_wr = 1'b0;
  logic [SEL_W-1:0] sel_wd = '0;
  logic [PRE_W-1:0] pre_wd = '0;
  logic [DIV_W-1:0] div_wd = '0;
  logic trig_set = 1'b0, pre_trig_set = 1'b0;
  logic trig_busy, pre_trig_busy, tick;
  logic [SEL_W-1:0] act_sel;
  logic [PRE_W-1:0] act_pre;
  logic [DIV_W-1:0] act_div;

  int checks = 0, errors = 0;
  int cyc_cnt = 0;

  always #2 clk = ~clk;

  cr_clk_rate dut (
    .clk_i(clk), .rst_ni(rst_ni), .src_tick_i(src_tick), .gate_en_i(gate_en),
    .sel_wr_i(sel_wr), .sel_wdata_i(sel_wd), .pre_wr_i(pre_wr), .pre_wdata_i(pre_wd),
    .div_wr_i(div_wr), .div_wdata_i(div_wd), .trig_set_i(trig_set),
    .pre_trig_set_i(pre_trig_set), .trig_busy_o(trig_busy),
    .pre_trig_busy_o(pre_trig_busy), .act_sel_o(act_sel), .act_pre_o(act_pre),
    .act_div_o(act_div), .tick_o(tick)
  );

  // parent i ticks once every i+1 cycles
  initial begin
    forever begin
      @(negedge clk);
      cyc_cnt++;
      for (int i = 0; i < NUM_SRC; i++) src_tick[i] = ((cyc_cnt % (i + 1)) == 0);
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int per_lo(input int div, input int k);
    return (k * (div + ONE)) / ONE;
  endfunction
  function automatic int per_hi(input int div, input int k);
    return (k * (div + ONE) + ONE - 1) / ONE;
  endfunction

  task automatic stage(input int s, input int p, input int d);
    sel_wd = SEL_W'(s); pre_wd = PRE_W'(p); div_wd = DIV_W'(d);
    sel_wr = 1'b1; pre_wr = 1'b1; div_wr = 1'b1;
    @(negedge clk);
    sel_wr = 1'b0; pre_wr = 1'b0; div_wr = 1'b0;
  endtask

  task automatic pulse_trig(input bit pre);
    if (pre) pre_trig_set = 1'b1; else trig_set = 1'b1;
    @(negedge clk);
    pre_trig_set = 1'b0; trig_set = 1'b0;
  endtask

  task automatic wait_idle(input string req);
    int n = 0;
    while ((trig_busy || pre_trig_busy) && n < 5000) begin
      @(negedge clk); n++;
    end
    chk(n < 5000, req, "trigger completes", n, 0);
  endtask

  task automatic count_ticks(input int cycles, output int n);
    n = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (tick) n++;
    end
  endtask

  task automatic measure(input int p, input int pre, input int div, input string req);
    int q = p * (pre + 1);
    int total = 0;
    int c = 0;
    while (!tick && c < 4000) begin @(negedge clk); c++; end
    chk(c < 4000, req, "first tick seen", c, 0);
    for (int i = 0; i < K; i++) begin
      c = 0;
      do begin @(negedge clk); c++; end while (!tick && c < 4000);
      chk(c == q * per_lo(div, 1) || c == q * per_hi(div, 1), req, "period cycles",
          c, q * per_lo(div, 1));
      total += c;
    end
    chk(total == q * per_lo(div, K) || total == q * per_hi(div, K), req,
        "sum of periods", total, q * per_lo(div, K));
  endtask

  initial begin
    int n;
    int s, p, d;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(act_sel == 2'd3, "R1", "act_sel", act_sel, 3);
    chk(act_pre == 0 && act_div == 0, "R1", "act_pre/div", {act_pre, act_div}, 0);
    chk(!trig_busy && !pre_trig_busy, "R1", "busy", {trig_busy, pre_trig_busy}, 0);
    chk(!tick, "R1", "tick_o", tick, 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R10 undefined selection keeps output low
    gate_en = 1'b1;
    count_ticks(60, n);
    chk(n == 0, "R10", "ticks under undefined sel", n, 0);

    // R8 triggers while gated are ignored
    gate_en = 1'b0;
    stage(0, 0, 5);
    pulse_trig(1'b0);
    chk(!trig_busy, "R8", "main busy when gated", trig_busy, 0);
    pulse_trig(1'b1);
    chk(!pre_trig_busy, "R8", "pre busy when gated", pre_trig_busy, 0);
    repeat (5) @(negedge clk);
    chk(act_div == 0 && act_sel == 2'd3, "R8", "active unchanged", act_div, 0);

    // R6 / R10 main trigger commits next cycle under undefined sel
    gate_en = 1'b1;
    pulse_trig(1'b0);
    chk(trig_busy, "R6", "busy after set", trig_busy, 1);
    @(negedge clk);
    chk(!trig_busy && act_div == 5, "R10", "quick commit act_div", act_div, 5);
    // R7 main trigger leaves staged selector alone
    chk(act_sel == 2'd3, "R7", "sel not committed by main", act_sel, 3);
    pulse_trig(1'b1);
    wait_idle("R7");
    chk(act_sel == 0 && act_pre == 0, "R7", "pre-trigger commits sel", act_sel, 0);

    // R3 fractional divisor 2.25
    measure(1, 0, 5, "R3");
    // R2 integer divisor 3.0
    stage(0, 0, 8);
    pulse_trig(1'b0);
    wait_idle("R2");
    measure(1, 0, 8, "R2");

    // R5 staged write without trigger has no effect
    stage(0, 0, 12);
    repeat (10) @(negedge clk);
    chk(act_div == 8, "R5", "act_div before trigger", act_div, 8);
    measure(1, 0, 8, "R5");

    // R6 commit coincides with tick_o
    pulse_trig(1'b0);
    chk(trig_busy, "R6", "busy after set", trig_busy, 1);
    n = 0;
    while (trig_busy && n < 100) begin @(negedge clk); n++; end
    chk(tick == 1'b1, "R6", "tick_o at clear", tick, 1);
    chk(act_div == 12, "R6", "act_div at clear", act_div, 12);

    // R4 pre-divider 3 on parent 1 (period 2), divisor 4.0
    stage(1, 2, 12);
    pulse_trig(1'b1);
    wait_idle("R4");
    chk(act_sel == 1 && act_pre == 2, "R4", "pre commit", act_pre, 2);
    measure(2, 2, 12, "R4");

    // R9 gate low silences output
    gate_en = 1'b0;
    @(negedge clk);
    count_ticks(80, n);
    chk(n == 0, "R9", "ticks while gated", n, 0);
    gate_en = 1'b1;

    // random configurations, R3 and R4
    for (int t = 0; t < 10; t++) begin
      s = int'($urandom % 3);
      p = int'($urandom % 3);
      d = int'($urandom % 64);
      stage(s, p, d);
      pulse_trig(1'b1);
      wait_idle("R4");
      pulse_trig(1'b0);
      wait_idle("R3");
      chk(act_div == DIV_W'(d), "R3", "random act_div", act_div, d);
      measure(s + 1, p, d, "R3");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired (all R)");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule